// File: doc/BRIEF.md
# Instruction-Fetch Address Break Comparator

This block watches every cycle on a CPU-side bus and compares it against a 32-bit address and a set of cycle-type conditions that software has loaded. On a match it issues a one-cycle break request. It also presents the matching address as the program counter value the exception sequence must save. For a fetch-cycle match, the break lands before the fetched instruction runs. That instruction is skipped, and the saved value points at it. If the previous instruction can take an interrupt, break handling begins once that previous instruction finishes.

The address is loaded as two 16-bit halves through a small register port. A 16-bit condition register holds four 2-bit fields: which master, fetch or data, read or write, and access size. Two fetch rules follow from how the CPU works. A condition that asks for a fetch with write access can never fire, because fetches are always reads. Fetches use only even addresses, so a programmed odd fetch address can match only a faulty fetch. That faulty fetch also raises an address error. The address error is handled first, and the break request follows it.

Top module: `brk_fetch_unit`

## Requirements
- R1: After reset, all three registers read 0x0000, `brk_req` is low and `saved_pc` is zero. With the condition register at zero, no bus cycle produces a break.
- R2: Register select values:
  - `reg_sel`=0 writes and reads the upper address half.
  - `reg_sel`=1 writes and reads the lower address half.
  - `reg_sel`=2 writes and reads the full 16-bit condition register.
  - `reg_rdata` follows `reg_sel` combinationally. Any other select reads zero.
- R3: A cycle matches only when all 32 bits of `bus_addr` equal {upper half, lower half}.
- R4: Condition bits 7:6 select the master and bits 5:4 select the cycle kind. Bits 3:2 select the direction. In each of these three fields, 01, 10 and 11 mean:
  - bits 7:6: 01 = CPU (`bus_cpu`=1), 10 = other master, 11 = either.
  - bits 5:4: 01 = instruction fetch, 10 = data access, 11 = either.
  - bits 3:2: 01 = read, 10 = write, 11 = either.
  - In any of these three fields, 00 means no break.
- R5: Condition bits 1:0 give the size: 00 leaves size out of matching, 01 byte, 10 word, 11 long. A nonzero code must equal `bus_size`, which uses the same codes.
- R6: A condition of fetch (bits 5:4 = 01) with write (bits 3:2 = 10) never matches, even if the bus shows a fetch with `bus_write` high.
- R7: A match sampled with `addr_err` low raises `brk_req` for exactly one cycle, one clock after the matching cycle. In that same cycle `saved_pc` shows the matching address.
- R8: Once a break is raised, it stays pending until `brk_ack` is sampled high. While it is pending, further matches (including one in the acknowledge cycle) raise nothing and leave `saved_pc` unchanged. After the acknowledge, the next match breaks again.
- R9: Address-error ordering:
  - A match sampled with `addr_err` high captures its address but raises no break while `addr_err` stays high.
  - `brk_req` pulses one clock after the first cycle in which `addr_err` is sampled low.
  - Matches during this wait are ignored.
- R10: With an odd address programmed for a fetch condition, an even fetch at the neighbouring address does not match. An odd fetch at that address, which arrives together with an address error, produces the deferred break of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 upper address, 1 lower address, 2 condition |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_cpu | input | 1 | 1 = cycle issued by the CPU, 0 = other master |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 01 byte, 10 word, 11 long |
| bus_addr | input | 32 | Bus cycle address |
| addr_err | input | 1 | Address-error exception being taken this clock |
| brk_ack | input | 1 | Break request accepted by the CPU |
| brk_req | output | 1 | One-cycle break request |
| saved_pc | output | 32 | Address to save as the program counter |

## Verification
The comparator is tried with several kinds of cycle:
- CPU fetch reads at the programmed address, and at an address differing only in the upper half. These separate a full 32-bit compare from a partial one.
- Data cycles, other-master cycles and each condition field set to zero. These show that each field gates the match on its own.
- Fetches with write shown on the bus under a fetch-write condition, set against data writes under a data-write condition. This shows that the void rule is specific to fetches.
- Byte against word data reads under a word size code.
- Repeated hits while a break is pending and in the acknowledge cycle, which expose any hold-off leak.
- An even and an odd fetch around an odd programmed address, with the address error held for several cycles. This fixes both the ordering and the exact cycle of the deferred break.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DEFER = 2'd1,
    SEQ_PEND  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [1:0] master;
    logic [1:0] kind;
    logic [1:0] dir;
    logic [1:0] size;
  } cond_fields_t;

  localparam logic [1:0] SEL_NONE  = 2'b00;
  localparam logic [1:0] SEL_FIRST = 2'b01;
  localparam logic [1:0] SEL_OTHER = 2'b10;
  localparam logic [1:0] SEL_BOTH  = 2'b11;

  // Two-way selector field: FIRST wants flag high, OTHER wants it low.
  function automatic logic field_ok(input logic [1:0] code, input logic flag);
    logic ok;
    case (code)
      SEL_FIRST: ok = flag;
      SEL_OTHER: ok = ~flag;
      SEL_BOTH:  ok = 1'b1;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic size_ok(input logic [1:0] code, input logic [1:0] size);
    return (code == 2'b00) || (code == size);
  endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [ADDR_W-1:0] brk_addr,
  output logic [REG_W-1:0]  cond_q
);

  localparam int NUM_HALVES = ADDR_W / REG_W;

  logic [REG_W-1:0] half_q [NUM_HALVES];
  logic [REG_W-1:0] half_d [NUM_HALVES];
  logic [NUM_HALVES-1:0] half_en;
  logic             cond_en;
  logic [REG_W-1:0] cond_d;

  // Half 0 is the most significant part of the address.
  for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
    always_comb begin
      half_en[i] = wr_en && (sel == SEL_W'(i));
      half_d[i]  = half_en[i] ? wdata : half_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        half_q[i] <= '0;
      end else begin
        half_q[i] <= half_d[i];
      end
    end

    assign brk_addr[ADDR_W-1-i*REG_W -: REG_W] = half_q[i];
  end

  always_comb begin
    cond_en = wr_en && (sel == SEL_W'(NUM_HALVES));
    cond_d  = cond_en ? wdata : cond_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
    end else begin
      cond_q <= cond_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_HALVES; i++) begin
      if (sel == SEL_W'(i)) rdata = half_q[i];
    end
    if (sel == SEL_W'(NUM_HALVES)) rdata = cond_q;
  end

endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 16
) (
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic [7:0]        cond_lo,
  input  logic              bus_valid,
  input  logic              bus_cpu,
  input  logic              bus_ifetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit,
  output logic              cond_void
);

  localparam int NUM_HALVES = ADDR_W / REG_W;

  cond_fields_t          fields;
  logic [NUM_HALVES-1:0] half_eq;
  logic                  addr_eq;
  logic                  master_ok;
  logic                  kind_ok;
  logic                  dir_ok;
  logic                  sz_ok;

  assign fields = cond_fields_t'(cond_lo);

  for (genvar i = 0; i < NUM_HALVES; i++) begin : g_cmp
    assign half_eq[i] = (bus_addr[i*REG_W +: REG_W] == brk_addr[i*REG_W +: REG_W]);
  end

  always_comb begin
    addr_eq   = &half_eq;
    master_ok = field_ok(fields.master, bus_cpu);
    kind_ok   = field_ok(fields.kind, bus_ifetch);
    dir_ok    = field_ok(fields.dir, ~bus_write);
    sz_ok     = size_ok(fields.size, bus_size);
    // Fetches are reads only, so a fetch-with-write condition is void.
    cond_void = (fields.kind == SEL_FIRST) && (fields.dir == SEL_OTHER);
    hit       = bus_valid && addr_eq && master_ok && kind_ok && dir_ok
                && sz_ok && !cond_void;
  end

endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              addr_err,
  input  logic              brk_ack,
  output logic              brk_req,
  output logic [ADDR_W-1:0] saved_pc,
  output logic              busy,
  output logic              pend
);

  seq_state_t        state_q, state_d;
  logic              req_d;
  logic              pc_en;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    pc_en   = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (hit) begin
          pc_en = 1'b1;
          if (addr_err) begin
            state_d = SEQ_DEFER;
          end else begin
            state_d = SEQ_PEND;
            req_d   = 1'b1;
          end
        end
      end
      SEQ_DEFER: begin
        if (!addr_err) begin
          state_d = SEQ_PEND;
          req_d   = 1'b1;
        end
      end
      SEQ_PEND: begin
        if (brk_ack) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
    pc_d = pc_en ? bus_addr : saved_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      brk_req  <= 1'b0;
      saved_pc <= '0;
    end else begin
      state_q  <= state_d;
      brk_req  <= req_d;
      saved_pc <= pc_d;
    end
  end

  assign busy = (state_q != SEQ_IDLE);
  assign pend = (state_q == SEQ_PEND);

endmodule

// File: rtl/brk_fetch_unit.sv
module brk_fetch_unit #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 16,
  parameter int SEL_W  = $clog2(ADDR_W / REG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_cpu,
  input  logic              bus_ifetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              addr_err,
  input  logic              brk_ack,
  output logic              brk_req,
  output logic [ADDR_W-1:0] saved_pc
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] brk_addr;
  logic [REG_W-1:0]  cond_q;
  logic              hit;
  logic              cond_void;
  logic              seq_busy;
  logic              seq_pend;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  brk_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (reg_wr_en),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .brk_addr (brk_addr),
    .cond_q   (cond_q)
  );

  brk_match #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_match (
    .brk_addr   (brk_addr),
    .cond_lo    (cond_q[7:0]),
    .bus_valid  (bus_valid),
    .bus_cpu    (bus_cpu),
    .bus_ifetch (bus_ifetch),
    .bus_write  (bus_write),
    .bus_size   (bus_size),
    .bus_addr   (bus_addr),
    .hit        (hit),
    .cond_void  (cond_void)
  );

  brk_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit      (hit),
    .bus_addr (bus_addr),
    .addr_err (addr_err),
    .brk_ack  (brk_ack),
    .brk_req  (brk_req),
    .saved_pc (saved_pc),
    .busy     (seq_busy),
    .pend     (seq_pend)
  );

endmodule

// File: rtl/brk_fetch_unit_chk.sv
module brk_fetch_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              brk_req,
  input logic              brk_ack,
  input logic              addr_err,
  input logic [ADDR_W-1:0] saved_pc,
  input logic              hit,
  input logic              cond_void,
  input logic              busy,
  input logic              pend
);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  assert_err_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !$past(addr_err));

  assert_void_fetch_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cond_void |-> !hit);

  assert_hold_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(saved_pc));

  assert_req_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> pend);

  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && brk_ack) |=> !busy);

endmodule

bind brk_fetch_unit brk_fetch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .brk_req   (brk_req),
  .brk_ack   (brk_ack),
  .addr_err  (addr_err),
  .saved_pc  (saved_pc),
  .hit       (hit),
  .cond_void (cond_void),
  .busy      (seq_busy),
  .pend      (seq_pend)
);

// File: tb/brk_fetch_unit_test.sv
module brk_fetch_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        bus_valid, bus_cpu, bus_ifetch, bus_write;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr;
  logic        addr_err, brk_ack;
  logic        brk_req;
  logic [31:0] saved_pc;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  brk_fetch_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_cpu(bus_cpu), .bus_ifetch(bus_ifetch), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .addr_err(addr_err),
    .brk_ack(brk_ack), .brk_req(brk_req), .saved_pc(saved_pc)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_hi, m_lo, m_cond;
  int          m_mode;          // 0 idle, 1 waiting on address error, 2 pending
  logic        m_brk;
  logic [31:0] m_pc;

  function automatic bit pick(input logic [1:0] c, input bit want_first, input bit flag);
    if (c == 2'b11) return 1;
    if (c == 2'b01) return flag == want_first;
    if (c == 2'b10) return flag != want_first;
    return 0;
  endfunction

  function automatic bit model_hit();
    if (!bus_valid) return 0;
    if (bus_addr != {m_hi, m_lo}) return 0;
    if (m_cond[5:4] == 2'b01 && m_cond[3:2] == 2'b10) return 0;
    if (!pick(m_cond[7:6], 1, bus_cpu)) return 0;
    if (!pick(m_cond[5:4], 1, bus_ifetch)) return 0;
    if (!pick(m_cond[3:2], 0, bus_write)) return 0;
    if (m_cond[1:0] != 2'b00 && m_cond[1:0] != bus_size) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi <= 0; m_lo <= 0; m_cond <= 0; m_mode <= 0; m_brk <= 0; m_pc <= 0;
    end else begin
      m_brk <= 0;
      if (m_mode == 0) begin
        if (model_hit()) begin
          m_pc <= bus_addr;
          if (addr_err) m_mode <= 1;
          else begin m_mode <= 2; m_brk <= 1; end
        end
      end else if (m_mode == 1) begin
        if (!addr_err) begin m_mode <= 2; m_brk <= 1; end
      end else begin
        if (brk_ack) m_mode <= 0;
      end
      if (reg_wr_en) begin
        if (reg_sel == 0) m_hi <= reg_wdata;
        else if (reg_sel == 1) m_lo <= reg_wdata;
        else if (reg_sel == 2) m_cond <= reg_wdata;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check_all();
    logic [15:0] exp_rd;
    case (reg_sel)
      2'd0: exp_rd = m_hi;
      2'd1: exp_rd = m_lo;
      2'd2: exp_rd = m_cond;
      default: exp_rd = 16'h0;
    endcase
    checks++;
    if (brk_req !== m_brk) begin
      errors++;
      $display("FAIL %s brk_req actual %b expected %b at %0t", cur_req, brk_req, m_brk, $time);
    end
    checks++;
    if (saved_pc !== m_pc) begin
      errors++;
      $display("FAIL %s saved_pc actual %h expected %h at %0t", cur_req, saved_pc, m_pc, $time);
    end
    checks++;
    if (reg_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s reg_rdata actual %h expected %h at %0t", cur_req, reg_rdata, exp_rd, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] sel);
    reg_sel = sel;
    tick();
  endtask

  task automatic cyc(input logic cpu, input logic fetch, input logic wr_b,
                     input logic [1:0] sz, input logic [31:0] a);
    bus_valid = 1; bus_cpu = cpu; bus_ifetch = fetch; bus_write = wr_b;
    bus_size = sz; bus_addr = a;
    tick();
    bus_valid = 0;
  endtask

  task automatic ack();
    brk_ack = 1;
    tick();
    brk_ack = 0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog %s: actual hung run, expected completion", cur_req);
    finish_up();
  end

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_sel = 0; reg_wdata = 0;
    bus_valid = 0; bus_cpu = 0; bus_ifetch = 0; bus_write = 0; bus_size = 0;
    bus_addr = 0; addr_err = 0; brk_ack = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1: reset values and no break with an empty condition register
    cur_req = "R1";
    rd(0); rd(1); rd(2); rd(3);
    cyc(1, 1, 0, 2'b10, 32'h0); tick();

    // R2: register write and read back
    cur_req = "R2";
    wr(0, 16'h0000); wr(1, 16'h0404); wr(2, 16'h0054);
    rd(0); rd(1); rd(2); rd(3);
    wr(0, 16'hA5C3); rd(0); wr(0, 16'h0000); rd(0);

    // R3 / R7: full-address compare, one-cycle break with saved address
    cur_req = "R3";
    cyc(1, 1, 0, 2'b10, 32'h0001_0404); tick();
    cyc(1, 1, 0, 2'b10, 32'h0000_0406); tick();
    cur_req = "R7";
    cyc(1, 1, 0, 2'b10, 32'h0000_0404); tick(); tick();
    ack(); tick();

    // R4: master, kind and direction fields
    cur_req = "R4";
    cyc(1, 0, 0, 2'b10, 32'h0000_0404); tick();   // data read, fetch wanted
    cyc(0, 1, 0, 2'b10, 32'h0000_0404); tick();   // other master
    cyc(1, 1, 1, 2'b10, 32'h0000_0404); tick();   // write, read wanted
    wr(2, 16'h0094);                             // other master, fetch, read
    cyc(0, 1, 0, 2'b10, 32'h0000_0404); tick(); ack();
    wr(2, 16'h00FC);                             // any master, kind, dir
    cyc(1, 0, 1, 2'b11, 32'h0000_0404); tick(); ack();
    wr(2, 16'h0014);                             // master field zero
    cyc(1, 1, 0, 2'b10, 32'h0000_0404); tick();
    wr(2, 16'h0044);                             // kind field zero
    cyc(1, 1, 0, 2'b10, 32'h0000_0404); tick();
    wr(2, 16'h0050);                             // direction field zero
    cyc(1, 1, 0, 2'b10, 32'h0000_0404); tick();

    // R6: fetch-with-write condition is void
    cur_req = "R6";
    wr(0, 16'h0015); wr(1, 16'h389C); wr(2, 16'h0058);
    cyc(1, 1, 0, 2'b10, 32'h0015_389C); tick();
    cyc(1, 1, 1, 2'b10, 32'h0015_389C); tick();
    wr(2, 16'h0068);                             // data write contrast
    cyc(1, 0, 1, 2'b10, 32'h0015_389C); tick(); ack();

    // R5: size field
    cur_req = "R5";
    wr(2, 16'h0066);                             // CPU, data, read, word
    cyc(1, 0, 0, 2'b01, 32'h0015_389C); tick();
    cyc(1, 0, 0, 2'b11, 32'h0015_389C); tick();
    cyc(1, 0, 0, 2'b10, 32'h0015_389C); tick(); ack();

    // R8: hold-off while pending, ack-cycle hit ignored
    cur_req = "R8";
    wr(0, 16'h0000); wr(1, 16'h0404); wr(2, 16'h0054);
    cyc(1, 1, 0, 2'b10, 32'h0000_0404);
    wr(1, 16'h0408);
    cyc(1, 1, 0, 2'b10, 32'h0000_0408); tick();
    cyc(1, 1, 0, 2'b10, 32'h0000_0408);
    brk_ack = 1; cyc(1, 1, 0, 2'b10, 32'h0000_0408); brk_ack = 0;
    tick();
    cyc(1, 1, 0, 2'b10, 32'h0000_0408); tick(); ack();

    // R10 / R9: odd programmed fetch address and address-error ordering
    cur_req = "R10";
    wr(0, 16'h0003); wr(1, 16'h0147); wr(2, 16'h0054);
    cyc(1, 1, 0, 2'b10, 32'h0003_0146); tick();
    cyc(1, 1, 0, 2'b10, 32'h0003_0148); tick();
    cur_req = "R9";
    addr_err = 1;
    cyc(1, 1, 0, 2'b10, 32'h0003_0147);
    tick();
    cyc(1, 1, 0, 2'b10, 32'h0003_0147);          // ignored during the wait
    tick();
    addr_err = 0;
    tick(); tick(); tick();
    ack(); tick();
    addr_err = 1; tick(); addr_err = 0; tick();   // error without a match

    finish_up();
  end

endmodule